// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a transmitter against a station that never stops sending. It watches the transmit-enable input and the transmit data line. When activity lasts past a long threshold, it declares a jabber condition. In that condition it turns off the line driver, turns off the collision-detect and internal-loopback paths, and raises a jabber flag and a collision-status flag. It leaves the jabber condition only after a long quiet interval. The interval counts while transmit enable is low, or while the data line has stopped toggling. Any renewed activity during the interval starts it again from zero.

Both intervals come from prescaled counters, and every length is a parameter in clock cycles. The default values give a 10 us tick at 125 MHz, a 20 ms trip time, a 500 ms release time and a 2 us toggle gap. A power-good input holds the block idle and keeps every output low. This stops the flags from lighting during supply ramps.

The controller has three states: `ST_IDLE`, `ST_TIMING` and `ST_JABBED`. Its transitions are:
- START: `ST_IDLE` to `ST_TIMING`, taken on activity.
- ABORT: `ST_TIMING` to `ST_IDLE`, taken when activity stops before the threshold.
- TRIP: `ST_TIMING` to `ST_JABBED`, taken when the activity timer reaches its limit.
- RELEASE: `ST_JABBED` to `ST_IDLE`, taken when the quiet timer reaches its limit.
- POWER_DROP: any state to `ST_IDLE`, taken while power-good is low.

Top module: `tx_jabber_guard`

## Requirements
- R1: With activity present at every rising edge, the jabber outputs rise after edge number ACT_LIMIT*PRESCALE+1, counted from the first active edge. They are low after every earlier edge.
- R2: In the jabber state, `drv_off`, `jab_flag`, `coll_flag` and `aux_off` are all 1. Outside it they are all 0.
- R3: If activity is absent at even one rising edge before the threshold, the activity count returns to zero. A full ACT_LIMIT*PRESCALE+1 active edges are then needed again.
- R4: In the jabber state with `tx_en` low, the outputs fall after quiet edge number QUIET_LIMIT*PRESCALE+1.
- R5: With `tx_en` held high, a quiet edge is one where the data line is not toggling. After the last data transition, the outputs fall IDLE_GAP+QUIET_LIMIT*PRESCALE+1 edges later.
- R6: In the jabber state, an edge with `tx_en` high and the data line toggling resets the quiet count to zero.
- R7: An edge is active when `tx_en` is 1, or when `tx_data` differs from its value at the previous edge, or when such a change occurred within the last IDLE_GAP edges. Data that changes every IDLE_GAP+1 cycles keeps the block active. Data that changes every IDLE_GAP+2 cycles does not.
- R8: While `pwr_ok` is 0, all four outputs are 0 in the same cycle, and no amount of activity raises them.
- R9: After `pwr_ok` returns to 1, the block starts from idle with cleared timers. Sustained activity then needs the full R1 count.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply good; 0 forces idle and inactive outputs |
| tx_en | input | 1 | Transmit enable |
| tx_data | input | 1 | Transmit data line |
| drv_off | output | 1 | Disables the line driver |
| jab_flag | output | 1 | Jabber condition indicator |
| coll_flag | output | 1 | Collision status, raised during jabber |
| aux_off | output | 1 | Disables collision detection and internal loopback |

## Verification
The bench builds the block with PRESCALE=3, ACT_LIMIT=4, QUIET_LIMIT=5, IDLE_GAP=2 and CNT_W=4. With these values the trip comes on the 13th active edge and the release on the 16th quiet edge. That makes both thresholds short enough to check the outputs after every single edge up to the boundary. The two-cycle gap puts the toggle-rate boundary between data periods of three and four cycles, so both sides of it can be driven directly. Power loss, restarted quiet time and an aborted activity run are each placed at chosen cycles inside these short windows.

// File: rtl/tjg_pkg.sv
package tjg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_JABBED  = 2'd2
    } jab_state_e;
endpackage

// File: rtl/tjg_activity.sv
// Activity classifier: detects data transitions and stretches each one over
// an idle gap so that slow but continuous toggling still counts as activity.
module tjg_activity #(
    parameter int IDLE_GAP = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_data,
    output logic active,
    output logic busy
);
    localparam int GAP_W = $clog2(IDLE_GAP + 1);

    logic             txd_q;
    logic [GAP_W-1:0] gap;
    logic             edge_now;
    logic             toggling;

    assign edge_now = (tx_data != txd_q);
    assign toggling = edge_now || (gap != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd_q <= 1'b0;
            gap   <= '0;
        end else begin
            txd_q <= tx_data;
            if (edge_now)
                gap <= GAP_W'(IDLE_GAP);
            else if (gap != '0)
                gap <= gap - 1'b1;
        end
    end

    // Activity for the trip timer: either source suffices.
    assign active = tx_en || toggling;
    // Activity that blocks release: enable high and data still moving.
    assign busy   = tx_en && toggling;

    a_r7_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GAP_W'(IDLE_GAP));

    a_r7_edge_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data != txd_q) |=> (gap == GAP_W'(IDLE_GAP)));
endmodule

// File: rtl/tjg_timer.sv
// Prescaled saturating interval timer. Cleared whenever run is low.
module tjg_timer #(
    parameter int PRESCALE = 1250,
    parameter int LIMIT    = 2000,
    parameter int CNT_W    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] cnt;
    logic             tick;

    generate
        if (PRESCALE > 1) begin : g_pre
            localparam int PRE_W = $clog2(PRESCALE + 1);
            logic [PRE_W-1:0] pre;
            assign tick = run && (pre == PRE_W'(PRESCALE - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pre <= '0;
                else if (!run || tick)
                    pre <= '0;
                else
                    pre <= pre + 1'b1;
            end
        end else begin : g_nopre
            assign tick = run;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (tick && (cnt != CNT_W'(LIMIT)))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == CNT_W'(LIMIT));

    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LIMIT));

    a_r3_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/tjg_fsm.sv
// Three-state jabber controller.
module tjg_fsm
    import tjg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic active,
    input  logic busy,
    input  logic act_done,
    input  logic quiet_done,
    output logic act_run,
    output logic quiet_run,
    output logic jab_out
);
    jab_state_e st, st_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        if (!pwr_ok) begin
            st_nxt = ST_IDLE;                          // POWER_DROP
        end else begin
            unique case (st)
                ST_IDLE:   if (active) st_nxt = ST_TIMING;      // START
                ST_TIMING: begin
                    if (act_done)     st_nxt = ST_JABBED;       // TRIP
                    else if (!active) st_nxt = ST_IDLE;         // ABORT
                end
                ST_JABBED: if (quiet_done) st_nxt = ST_IDLE;    // RELEASE
                default:   st_nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        act_run   = 1'b0;
        quiet_run = 1'b0;
        jab_out   = 1'b0;
        if (pwr_ok) begin
            unique case (st)
                ST_IDLE, ST_TIMING: act_run = active;
                ST_JABBED: begin
                    quiet_run = !busy;
                    jab_out   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r1_no_early_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_JABBED && !act_done) |=> (st != ST_JABBED));

    a_r4_hold_until_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_JABBED && pwr_ok && !quiet_done) |=> (st == ST_JABBED));

    a_r8_idle_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (st == ST_IDLE));
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
    parameter int PRESCALE    = 1250,
    parameter int ACT_LIMIT   = 2000,
    parameter int QUIET_LIMIT = 50000,
    parameter int IDLE_GAP    = 250,
    parameter int CNT_W       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic tx_en,
    input  logic tx_data,
    output logic drv_off,
    output logic jab_flag,
    output logic coll_flag,
    output logic aux_off
);
    logic active, busy;
    logic act_run, quiet_run;
    logic act_done, quiet_done;
    logic jab_out;

    tjg_activity #(.IDLE_GAP(IDLE_GAP)) u_act (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
        .active(active), .busy(busy)
    );

    tjg_timer #(.PRESCALE(PRESCALE), .LIMIT(ACT_LIMIT), .CNT_W(CNT_W)) u_trip (
        .clk(clk), .rst_n(rst_n), .run(act_run), .done(act_done)
    );

    tjg_timer #(.PRESCALE(PRESCALE), .LIMIT(QUIET_LIMIT), .CNT_W(CNT_W)) u_quiet (
        .clk(clk), .rst_n(rst_n), .run(quiet_run), .done(quiet_done)
    );

    tjg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
        .active(active), .busy(busy),
        .act_done(act_done), .quiet_done(quiet_done),
        .act_run(act_run), .quiet_run(quiet_run), .jab_out(jab_out)
    );

    assign drv_off   = jab_out;
    assign jab_flag  = jab_out;
    assign coll_flag = jab_out;
    assign aux_off   = jab_out;

    a_r8_no_flag_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> !jab_flag);

    a_r6_busy_blocks_release: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_flag && busy && pwr_ok) |=> jab_flag);
endmodule

// File: tb/sim_tx_jabber_guard.sv
module sim_tx_jabber_guard;
    localparam int PS = 3, AL = 4, QL = 5, GP = 2;
    localparam int TRIP = AL * PS + 1;   // 13
    localparam int REL  = QL * PS + 1;   // 16

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic tx_en = 1'b0;
    logic tx_data = 1'b0;
    logic drv_off, jab_flag, coll_flag, aux_off;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tx_jabber_guard #(.PRESCALE(PS), .ACT_LIMIT(AL), .QUIET_LIMIT(QL),
                      .IDLE_GAP(GP), .CNT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .tx_en(tx_en),
        .tx_data(tx_data), .drv_off(drv_off), .jab_flag(jab_flag),
        .coll_flag(coll_flag), .aux_off(aux_off)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Optionally flip data, then pass one rising edge; returns at the falling edge.
    task automatic cyc(input bit flip);
        if (flip) tx_data = ~tx_data;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiesce();
        tx_en = 1'b0;
        repeat (20) cyc(1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(jab_flag, 1'b0, "R10", "jab_flag after reset");
        chk(drv_off,  1'b0, "R10", "drv_off after reset");
        chk(coll_flag,1'b0, "R10", "coll_flag after reset");
        chk(aux_off,  1'b0, "R10", "aux_off after reset");

        // R1 trip sweep with enable held high
        tx_en = 1'b1;
        for (int i = 1; i <= TRIP; i++) begin
            cyc(1'b0);
            chk(jab_flag, (i >= TRIP), "R1", $sformatf("edge %0d", i));
        end
        // R2 all outputs in jabber
        chk(drv_off,   1'b1, "R2", "drv_off in jabber");
        chk(coll_flag, 1'b1, "R2", "coll_flag in jabber");
        chk(aux_off,   1'b1, "R2", "aux_off in jabber");
        // R4 release sweep with enable low
        tx_en = 1'b0;
        for (int i = 1; i <= REL; i++) begin
            cyc(1'b0);
            chk(jab_flag, (i < REL), "R4", $sformatf("quiet edge %0d", i));
        end
        chk(drv_off, 1'b0, "R2", "drv_off after release");
        chk(aux_off, 1'b0, "R2", "aux_off after release");
        quiesce();

        // R3 aborted run restarts the count
        tx_en = 1'b1;
        repeat (10) cyc(1'b0);
        tx_en = 1'b0;
        cyc(1'b0);
        chk(jab_flag, 1'b0, "R3", "after gap edge");
        tx_en = 1'b1;
        for (int i = 1; i <= TRIP; i++) begin
            cyc(1'b0);
            chk(jab_flag, (i >= TRIP), "R3", $sformatf("restart edge %0d", i));
        end
        quiesce();

        // R7 toggle-only activity: period GP+1 trips, period GP+2 does not
        for (int per = GP + 1; per <= GP + 2; per++) begin
            tx_en = 1'b0;
            for (int i = 0; i < 20; i++) begin
                cyc((i % per) == 0);
                chk(jab_flag, (per == GP + 1) && (i + 1 >= TRIP), "R7",
                    $sformatf("period %0d edge %0d", per, i + 1));
            end
            quiesce();
        end

        // R5 release by data going still while enable stays high
        tx_en = 1'b1;
        for (int i = 1; i <= 20; i++) cyc(1'b1);
        chk(jab_flag, 1'b1, "R5", "jabber while toggling");
        for (int j = 1; j <= GP + REL; j++) begin
            cyc(1'b0);
            chk(jab_flag, (j < GP + REL), "R5", $sformatf("still edge %0d", j));
        end
        quiesce();

        // R6 busy edge restarts quiet time
        tx_en = 1'b1;
        repeat (TRIP) cyc(1'b0);
        chk(jab_flag, 1'b1, "R6", "jabber before restart");
        tx_en = 1'b0;
        repeat (8) cyc(1'b0);
        tx_en = 1'b1;
        cyc(1'b1);
        tx_en = 1'b0;
        for (int j = 1; j <= REL; j++) begin
            cyc(1'b0);
            chk(jab_flag, (j < REL), "R6", $sformatf("post-restart edge %0d", j));
        end
        quiesce();

        // R8 power loss forces outputs low at once
        tx_en = 1'b1;
        repeat (TRIP) cyc(1'b0);
        chk(jab_flag, 1'b1, "R8", "jabber before power loss");
        pwr_ok = 1'b0;
        #1;
        chk(jab_flag,  1'b0, "R8", "jab_flag unpowered");
        chk(drv_off,   1'b0, "R8", "drv_off unpowered");
        chk(coll_flag, 1'b0, "R8", "coll_flag unpowered");
        chk(aux_off,   1'b0, "R8", "aux_off unpowered");
        for (int i = 1; i <= 30; i++) begin
            cyc(1'b1);
            chk(jab_flag, 1'b0, "R8", $sformatf("unpowered edge %0d", i));
        end
        // R9 full count after power returns
        tx_data = tx_data;
        pwr_ok = 1'b1;
        for (int i = 1; i <= TRIP; i++) begin
            cyc(1'b0);
            chk(jab_flag, (i >= TRIP), "R9", $sformatf("repowered edge %0d", i));
        end
        quiesce();
        chk(jab_flag, 1'b0, "R10", "final idle");

        finish_run();
    end
endmodule